// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the bit-rate timing for a serial port from a fixed reference clock. An integer prescaler divides the reference clock by a programmable amount. Each time the prescaler wraps, a programmable fractional step is added into a phase accumulator. Each carry out of the accumulator produces one single-cycle tick on the output, so the long-run tick rate is `clk / (scale + 1) * step / 2^17`.

The integrator picks the scale and step values for the wanted bit rate. It then presents both as one packed configuration word and holds enable high. A change of the word, or a low enable, restarts the phase from zero, so no leftover phase from an earlier setting can produce a tick. Framing, sampling and the search for the best scale and step are left to the logic around the block.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `tick_o` is low.
- R2: The configuration word carries the step in bits 15:0 and the scale in bits 23:16.
- R3: The prescaler lets the accumulator advance once every scale+1 clock cycles, counting from the first enabled edge. With scale 2 and step 32768, the first tick appears after the 12th enabled edge.
- R4: The phase accumulator is 17 bits wide, and a carry out of its bit 16 makes exactly one tick, registered on the same edge as the add. With scale 0 and step 32768, a tick follows every 4th enabled edge, starting with the 4th.
- R5: Over a long window, the tick count matches `floor(cycles/(scale+1)) * step / 2^17` to within one tick.
- R6: A tick lasts one cycle, and two ticks never fall on consecutive cycles.
- R7: A step of 0 produces no ticks, whatever the scale.
- R8: When the configuration word differs from its value on the previous edge, both counters clear on that edge and no tick is emitted. The phase then restarts from zero.
- R9: While enable is low, no tick is emitted and both counters are held at zero. After enable returns, timing restarts as from a fresh start.
- R10: Scale 0 with step 65535 gives the highest rate, just under one tick per two cycles. Scale 255 with step 1 gives the lowest rate, with no tick within the first 2^17 * 256 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears and holds the generator |
| cfg_i | input | 24 | Packed configuration: scale in 23:16, step in 15:0 |
| tick_o | output | 1 | Single-cycle bit-rate tick |

## Verification
A wrong prescale count or a wrong accumulator width moves the first tick away from its exact edge after a restart. This shows within a dozen cycles, so the bench checks those first ticks edge by edge. A phase left over from before a configuration change or a disable pulls the next tick earlier by a few cycles, and the bench checks the edge of the first tick after each restart. A small drift in the accumulation only builds up over many periods, so long counting windows at several scale and step pairs compare the tick total against the rate formula.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned SCALE_W = 8;
  localparam int unsigned STEP_W  = 16;
  localparam int unsigned ACC_W   = STEP_W + 1;
  localparam int unsigned CFG_W   = SCALE_W + STEP_W;

  typedef struct packed {
    logic [SCALE_W-1:0] scale;
    logic [STEP_W-1:0]  step;
  } cfg_t;
endpackage

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             stb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap  = (cnt_q == limit_i);
  assign stb_o = wrap & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (wrap)        cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
  parameter int unsigned STEP_W = 16,
  localparam int unsigned ACC_W = STEP_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;
  logic             tick_q;

  // extra top bit of sum is the carry out of the accumulator
  assign sum    = {1'b0, acc_q} + {{(ACC_W + 1 - STEP_W){1'b0}}, step_i};
  assign tick_o = tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (adv_i) begin
      acc_q  <= sum[ACC_W-1:0];
      tick_q <= sum[ACC_W];
    end else begin
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             tick_o
);
  cfg_t cfg;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             clr;
  logic             pre_stb;

  assign cfg     = cfg_t'(cfg_i);
  assign cfg_chg = (cfg_i != cfg_q);
  assign clr     = ~en_i | cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_i;
  end

  fbg_prescale #(.CNT_W(SCALE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (cfg.scale),
    .stb_o   (pre_stb)
  );

  fbg_phase_acc #(.STEP_W(STEP_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (pre_stb),
    .step_i (cfg.step),
    .tick_o (tick_o)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk
  import fbg_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             tick_o,
  input logic             pre_stb
);
  logic seen_edge_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_edge_q <= 1'b0;
    else         seen_edge_q <= 1'b1;
  end

  always_comb begin
    if (!rst_ni) p_reset_quiet_r1: assert (!tick_o);
  end

  p_tick_after_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> $past(pre_stb));

  p_single_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  p_zero_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[STEP_W-1:0] == '0) |=> !tick_o);

  p_cfg_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_edge_q && cfg_i != $past(cfg_i)) |=> !tick_o);

  p_idle_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);
endmodule

bind frac_baud_gen frac_baud_gen_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .cfg_i   (cfg_i),
  .tick_o  (tick_o),
  .pre_stb (pre_stb)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [23:0] cfg_i = '0;
  logic        tick_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  frac_baud_gen u0 (
    .clk_i (clk_i), .rst_ni(rst_ni), .en_i(en_i), .cfg_i(cfg_i), .tick_o(tick_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_near(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act > exp + 1 || act < exp - 1) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk_i);
    #2;
  endtask

  // disable for one edge with new cfg, re-enable; returns at negedge before first enabled edge
  task automatic arm(input logic [7:0] sc, input logic [15:0] st);
    @(negedge clk_i);
    en_i  = 1'b0;
    cfg_i = {sc, st};
    @(negedge clk_i);
    en_i  = 1'b1;
  endtask

  // over n edges expect a tick only after edge 'at' (0: none)
  task automatic expect_pattern(input string req, input int n, input int at);
    int bad_edge;
    bad_edge = 0;
    for (int k = 1; k <= n; k++) begin
      edge_sample();
      if (tick_o !== (k == at) && bad_edge == 0) bad_edge = k;
    end
    chk(req, bad_edge, 0);
  endtask

  task automatic t_reset();
    chk("R1 tick during reset", tick_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    edge_sample();
    chk("R1 tick after reset", tick_o, 0);
  endtask

  task automatic t_accum_width();
    arm(8'd0, 16'd32768);
    expect_pattern("R4 tick every 4th edge, first", 4, 4);
    expect_pattern("R4 tick every 4th edge, second", 4, 4);
  endtask

  task automatic t_prescale();
    arm(8'd2, 16'd32768);
    expect_pattern("R2 R3 scale field, first tick at edge 12", 12, 12);
  endtask

  task automatic t_window(input string req, input logic [7:0] sc, input logic [15:0] st,
                          input int w, input bit exact0);
    longint cnt, exp_t;
    int prev, adj;
    cnt = 0; prev = 0; adj = 0;
    arm(sc, st);
    for (int k = 0; k < w; k++) begin
      edge_sample();
      if (tick_o) begin
        cnt++;
        if (prev == 1) adj++;
      end
      prev = tick_o;
    end
    exp_t = ((longint'(w) / (longint'(sc) + 1)) * longint'(st)) / 131072;
    if (exact0) chk(req, cnt, 0);
    else        chk_near(req, cnt, exp_t);
    chk("R6 no back-to-back ticks", adj, 0);
  endtask

  task automatic t_cfg_change();
    arm(8'd0, 16'd32768);
    expect_pattern("R8 pre-change phase", 2, 0);
    @(negedge clk_i);
    cfg_i = {8'd0, 16'd32769};
    expect_pattern("R8 restart after cfg change", 5, 5);
  endtask

  task automatic t_disable();
    arm(8'd0, 16'd32768);
    expect_pattern("R9 pre-disable phase", 2, 0);
    @(negedge clk_i);
    en_i = 1'b0;
    expect_pattern("R9 no tick while disabled", 3, 0);
    @(negedge clk_i);
    en_i = 1'b1;
    expect_pattern("R9 restart after enable", 4, 4);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_accum_width();
    t_prescale();
    t_window("R10 R5 max rate", 8'd0, 16'd65535, 2000, 1'b0);
    t_window("R5 scale 3 step 1000", 8'd3, 16'd1000, 20000, 1'b0);
    t_window("R5 scale 7 step 40000", 8'd7, 16'd40000, 20000, 1'b0);
    t_window("R5 scale 255 step 65535", 8'd255, 16'd65535, 60000, 1'b0);
    t_window("R10 min rate silent", 8'd255, 16'd1, 5000, 1'b1);
    t_window("R7 step 0 scale 0", 8'd0, 16'd0, 3000, 1'b1);
    t_window("R7 step 0 scale 9", 8'd9, 16'd0, 3000, 1'b1);
    t_cfg_change();
    t_disable();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule